// File: doc/BRIEF.md
# Freezable Event Trace Capture Buffer

This block is an on-chip logic-analyser store. While capture is enabled it writes 64-bit event words from a debug bus into a 128-entry circular memory, one entry per cycle, and advances a 7-bit write pointer that wraps. A 16-bit event-select mask decides which events are kept. Each event carries a 4-bit kind, and the event is stored only when the mask bit with that index is set.

All control uses one 32-bit configuration and status word. Software clears the enable bit to freeze the buffer and reads the write pointer. It then sets the read pointer to each entry from the oldest to the newest and reads the selected entry on the 64-bit data port. Setting the enable bit again resumes capture at the frozen pointer.

In the two paired modes, each event fills two consecutive entries on two consecutive cycles. A status flag shows when a pair is only half written. In that state the entry after the first word is not yet valid and reads back as all ones.

Top module: `trace_capture_buf`

## Requirements
- R1: After reset the write pointer, read pointer, enable bit and mode field are zero and the half-pair flag (bit 23) is one.
- R2: In mode 0 or 1, with enable set, an accepted event stores `ev_word0` at the write pointer, and the pointer then moves up by one. It wraps from 127 to 0.
- R3: An event whose `ev_kind` value k points at a clear mask bit (config write bit 16+k) is dropped. No entry is written and the write pointer does not move.
- R4: While the enable bit (bit 12) is clear, no entry is written and the write pointer holds its value. Setting the bit again continues capture at that pointer.
- R5: In mode 2 or 3 (bits 15:14), an accepted event stores `ev_word0` at the write pointer. On the next enabled cycle it stores `ev_word1` at the following entry, so the pointer moves by two in total. Events that arrive while the second word is still pending are dropped.
- R6: The half-pair flag reads zero exactly while a second word is pending, and reads one at all other times. In modes 0 and 1 it is always one.
- R7: While the half-pair flag is zero, the entry at the write pointer reads back as all ones.
- R8: An entry that has not been written since reset reads back as all ones.
- R9: A config write sets the read pointer from bits 6:0. From the next cycle on, `rd_data` returns the selected entry. A write that changes the read pointer does not change the write pointer.
- R10: The status word reads the read pointer in bits 6:0, enable in bit 12, mode in bits 15:14, the write pointer in bits 22:16 and the half-pair flag in bit 23. All other bits read zero, and the mask cannot be read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | An event is offered this cycle |
| ev_kind | input | 4 | Event kind; indexes the select mask |
| ev_word0 | input | DW | First (or only) word of the event |
| ev_word1 | input | DW | Second word, used in the paired modes |
| cfg_we | input | 1 | Write strobe for the config word |
| cfg_wdata | input | 32 | Config write data: mask 31:16, mode 15:14, enable 12, read pointer 6:0 |
| cfg_rdata | output | 32 | Status word |
| rd_data | output | DW | Entry selected by the read pointer |

## Verification
A corrupted write pointer shows in status bits 22:16 in the cycle after the faulty edge, as a step other than zero, one, or a hold while frozen. A lost or stuck pending second word shows as a wrong half-pair flag in the same cycle, and as a pointer that moves by one instead of two. A wrong memory entry or a wrong fill bitmap stays hidden until software points the read pointer at that entry. The bench therefore sweeps the pointer through the whole buffer after freezing, so that each bad entry shows within a 128-cycle scan.

// File: rtl/trace_capture_buf.sv
module trace_capture_buf #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_valid,
  input  logic [3:0]    ev_kind,
  input  logic [DW-1:0] ev_word0,
  input  logic [DW-1:0] ev_word1,
  input  logic          cfg_we,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  output logic [DW-1:0] rd_data
);
  localparam int AW    = 7;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] filled;
  logic [AW-1:0]    wp, rp;
  logic             en, pend;
  logic [1:0]       mode;
  logic [15:0]      mask;
  logic [DW-1:0]    hold;

  wire take   = ev_valid & en & mask[ev_kind] & ~pend;
  wire finish = pend & en;
  wire wr     = take | finish;
  wire [DW-1:0] wdat = take ? ev_word0 : hold;

  always_ff @(posedge clk)
    if (wr) mem[wp] <= wdat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      filled <= '0;
      wp     <= '0;
      rp     <= '0;
      en     <= 1'b0;
      mode   <= 2'd0;
      mask   <= '0;
      pend   <= 1'b0;
      hold   <= '0;
    end else begin
      if (wr) begin
        filled[wp] <= 1'b1;
        wp         <= wp + 1'b1;
      end
      if (take && mode[1]) begin
        pend <= 1'b1;
        hold <= ev_word1;
      end else if (finish) begin
        pend <= 1'b0;
      end
      if (cfg_we) begin
        mask <= cfg_wdata[31:16];
        mode <= cfg_wdata[15:14];
        en   <= cfg_wdata[12];
        rp   <= cfg_wdata[AW-1:0];
      end
    end
  end

  assign rd_data   = (!filled[rp] || (pend && rp == wp)) ? {DW{1'b1}} : mem[rp];
  assign cfg_rdata = {8'h00, ~pend, wp, mode, 1'b0, en, 5'b00000, rp};
endmodule

module trace_capture_buf_chk #(
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [31:0]   cfg_wdata,
  input logic [31:0]   cfg_rdata,
  input logic [DW-1:0] rd_data
);
  wire [6:0] wpo  = cfg_rdata[22:16];
  wire       half = cfg_rdata[23];
  wire       eno  = cfg_rdata[12];

  a_r2_wptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wpo != $past(wpo)) |-> (wpo == $past(wpo) + 7'd1));

  a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!eno) |-> $stable(wpo));

  a_r6_half_mode: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(half) |-> ($past(cfg_rdata[15:14]) >= 2'd2));

  a_r7_open_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (!half && cfg_rdata[6:0] == wpo) |-> (rd_data == {DW{1'b1}}));

  a_r9_rptr_load: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg_rdata[6:0] == $past(cfg_wdata[6:0])));

  a_r10_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[31:24] == 8'h00) && (cfg_rdata[13] == 1'b0) && (cfg_rdata[11:7] == 5'd0));
endmodule

bind trace_capture_buf trace_capture_buf_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .rd_data(rd_data));

// File: tb/tb_trace_capture_buf.sv
`timescale 1ns/1ps
module tb_trace_capture_buf;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_valid = 1'b0;
  logic [3:0]  ev_kind = '0;
  logic [63:0] ev_word0 = '0, ev_word1 = '0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [63:0] rd_data;

  always #2.5 clk = ~clk;

  trace_capture_buf #(.DW(64)) dut (.*);

  int tests = 0, fails = 0;
  bit done = 1'b0;
  string req = "R1";

  logic [63:0] m_mem [128];
  bit          m_fill [128];
  logic [6:0]  m_wp = '0, m_rp = '0;
  bit          m_en = 0, m_pend = 0;
  logic [1:0]  m_mode = '0;
  logic [15:0] m_mask = '0;
  logic [63:0] m_hold = '0;

  function automatic logic [31:0] mk(input logic [15:0] mk_mask, input logic [1:0] md,
                                     input bit e, input logic [6:0] r);
    return {mk_mask, md, 1'b0, e, 5'b00000, r};
  endfunction

  function automatic logic [31:0] exp_cfg();
    return {8'h00, ~m_pend, m_wp, m_mode, 1'b0, m_en, 5'b00000, m_rp};
  endfunction

  function automatic logic [63:0] exp_data();
    if (!m_fill[m_rp] || (m_pend && m_rp == m_wp)) return '1;
    return m_mem[m_rp];
  endfunction

  task automatic check();
    tests++;
    if (cfg_rdata !== exp_cfg()) begin
      fails++;
      $display("FAIL %s status: got %h exp %h", req, cfg_rdata, exp_cfg());
    end
    tests++;
    if (rd_data !== exp_data()) begin
      fails++;
      $display("FAIL %s data rp=%0d: got %h exp %h", req, m_rp, rd_data, exp_data());
    end
  endtask

  task automatic step(input bit v, input logic [3:0] k, input logic [63:0] w0, w1,
                      input bit we, input logic [31:0] wd);
    bit take;
    @(negedge clk);
    ev_valid = v; ev_kind = k; ev_word0 = w0; ev_word1 = w1;
    cfg_we = we; cfg_wdata = wd;
    take = v && m_en && m_mask[k] && !m_pend;
    if (take) begin
      m_mem[m_wp] = w0; m_fill[m_wp] = 1;
      if (m_mode >= 2) begin m_hold = w1; m_pend = 1; end
      m_wp = m_wp + 7'd1;
    end else if (m_pend && m_en) begin
      m_mem[m_wp] = m_hold; m_fill[m_wp] = 1;
      m_wp = m_wp + 7'd1; m_pend = 0;
    end
    if (we) begin
      m_mask = wd[31:16]; m_mode = wd[15:14]; m_en = wd[12]; m_rp = wd[6:0];
    end
    @(posedge clk);
    #1;
    check();
  endtask

  task automatic ev(input logic [3:0] k);
    step(1'b1, k, {$urandom, $urandom}, {$urandom, $urandom}, 1'b0, '0);
  endtask

  task automatic cfg(input logic [31:0] wd);
    step(1'b0, 4'd0, '0, '0, 1'b1, wd);
  endtask

  task automatic sweep(input logic [15:0] mm, input logic [1:0] md, input bit e,
                       input logic [6:0] start);
    for (int i = 0; i < 128; i++) cfg(mk(mm, md, e, start + 7'(i)));
  endtask

  initial begin
    for (int i = 0; i < 128; i++) begin m_fill[i] = 0; m_mem[i] = '0; end
    void'($urandom(32'd12345));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #0.5;
    req = "R1"; check();
    req = "R10"; check();
    req = "R8"; sweep(16'h0000, 2'd0, 1'b0, 7'd0);

    req = "R2"; cfg(mk(16'hFFFF, 2'd0, 1'b1, 7'd0));
    for (int i = 0; i < 140; i++) ev(4'($urandom));
    req = "R9"; sweep(16'hFFFF, 2'd0, 1'b1, 7'd5);

    req = "R3"; cfg(mk(16'h0008, 2'd1, 1'b1, 7'd0));
    for (int i = 0; i < 60; i++) ev(4'($urandom));
    ev(4'd3); ev(4'd2);

    req = "R4"; cfg(mk(16'hFFFF, 2'd0, 1'b0, 7'd0));
    for (int i = 0; i < 20; i++) ev(4'($urandom));
    cfg(mk(16'hFFFF, 2'd0, 1'b1, m_wp));
    ev(4'd1); ev(4'd9);

    req = "R5"; cfg(mk(16'hFFFF, 2'd2, 1'b1, 7'd0));
    if (m_wp[0]) ev(4'd0);
    for (int i = 0; i < 80; i++) ev(4'($urandom));
    req = "R6"; cfg(mk(16'hFFFF, 2'd3, 1'b1, 7'd0));
    for (int i = 0; i < 30; i++) begin ev(4'($urandom)); step(0, 0, '0, '0, 0, '0); end

    req = "R7";
    while (m_pend) step(0, 0, '0, '0, 0, '0);
    step(1'b1, 4'd4, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 1'b1,
         mk(16'hFFFF, 2'd2, 1'b0, 7'd0));
    step(0, 0, '0, '0, 0, '0);
    cfg(mk(16'hFFFF, 2'd2, 1'b0, m_wp));
    sweep(16'hFFFF, 2'd2, 1'b0, m_wp + 7'd1);
    cfg(mk(16'hFFFF, 2'd2, 1'b1, m_wp));
    step(0, 0, '0, '0, 0, '0);

    req = "R9";
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 15) == 0)
        cfg(mk(16'($urandom), 2'($urandom), ($urandom_range(0, 3) != 0), 7'($urandom)));
      else
        step(($urandom_range(0, 1) == 1), 4'($urandom), {$urandom, $urandom},
             {$urandom, $urandom}, 1'b0, '0);
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule